// File: doc/BRIEF.md
# Event Counter Bank for a Memory Subsystem

This block counts activity in a memory subsystem. It holds a bank of general event counters and one free-running cycle counter, and all of them sit behind a simple register write/read port. Each general counter watches one of up to 64 single-bit event inputs. Its choice of event and its own enable live in an 8-bit lane, and the lanes are packed four to a 32-bit select word. A global control register clears the whole bank, starts counting or stops counting. A status register reports whether the bank is running.

Software seeds a general counter indirectly. It first writes a selector value of 19 plus the counter index to a test-select register, then writes the seed value to a preload register. Every general counter that wraps raises a one-cycle pulse on its own bit of `ovf_pulse`, and an interrupt block elsewhere collects these pulses. Reads are combinational from `reg_addr`. Writes take effect at the next rising clock edge.

Top module: `evt_ctr_bank`

## Requirements
- R1: After `rst_n` is asserted, every general counter, the cycle counter, the run state, the test selector and all select lanes are zero. Every mapped offset then reads zero.
- R2: A write to offset 0xC00 acts on the run state with a fixed priority. Bit 2 clears all general counters and the cycle counter and leaves the bank stopped. Otherwise bit 1 stops the bank. Otherwise bit 0 starts it. Bit 0 of offset 0xC04 reads the run state. Offset 0xC00 reads zero.
- R3: A general counter adds one on a clock edge only when all three of these hold in the preceding cycle: the run state is set, the enable bit of its lane is set, and the event input numbered by its lane is high.
- R4: The lane of counter n lies in the select word at 0xC68 + 4*(n/4), at bits 8*(n%4)+7 down to 8*(n%4). Within a lane, bit 7 is the enable and bits 5:0 are the event number. Bit 6 always reads 0. A lane of zero disables its counter.
- R5: General counter n reads at offset 0xC78 + 4*n. Writes to these offsets change nothing.
- R6: The 56-bit cycle counter adds one on every edge while the run state is set. Offset 0xC10 returns its upper 24 bits in bits 23:0. Offset 0xC14 returns its lower 32 bits. Writes to both offsets are ignored.
- R7: A general counter that increments from 0xFFFFFFFF wraps to 0. Its bit of `ovf_pulse` is high for exactly the one cycle in which the counter reads 0 after the wrap.
- R8: Offset 0xC08 stores and reads back an 8-bit selector. When the selector is 19+n for a valid index n, a write to 0xC0C loads the written value into counter n. That load wins over an increment in the same cycle. Other selector values make a preload write do nothing. Offset 0xC0C reads zero.
- R9: Offsets outside the map, and offsets not aligned to 4 bytes, read zero. Writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_addr | input | 12 | Byte offset for the write or the read |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| evt_in | input | NUM_EVT (64) | Event pulse inputs |
| ovf_pulse | output | NUM_CTR (16) | One-cycle wrap pulse for each general counter |

## Verification
The bench builds the block with its default parameters: 16 counters of 32 bits, 64 event inputs and a 56-bit cycle counter. With these values all four select words are fully populated, and every event number can be reached from some lane. A seed near 0xFFFFFFFF brings the 32-bit wrap and its pulse within a few cycles. The upper cycle word can only be seen at small values in a short run. That check therefore confirms its placement and its zero bits, and the carry into it is checked by a property instead.

// File: rtl/evt_pkg.sv
package evt_pkg;
    localparam int SEL_W     = 6;
    localparam int TSEL_BASE = 19;
    localparam int BUS_W     = 32;
    localparam int ADDR_W    = 12;

    localparam logic [ADDR_W-1:0] OFS_CTRL    = 12'hC00;
    localparam logic [ADDR_W-1:0] OFS_STATE   = 12'hC04;
    localparam logic [ADDR_W-1:0] OFS_TSEL    = 12'hC08;
    localparam logic [ADDR_W-1:0] OFS_PRELOAD = 12'hC0C;
    localparam logic [ADDR_W-1:0] OFS_CYC_HI  = 12'hC10;
    localparam logic [ADDR_W-1:0] OFS_CYC_LO  = 12'hC14;
    localparam logic [ADDR_W-1:0] OFS_SEL0    = 12'hC68;
    localparam logic [ADDR_W-1:0] OFS_CNT0    = 12'hC78;

    localparam int CTRL_START = 0;
    localparam int CTRL_STOP  = 1;
    localparam int CTRL_CLEAR = 2;

    typedef struct packed {
        logic             en;
        logic [SEL_W-1:0] evt;
    } lane_t;
endpackage

// File: rtl/evt_ctr_slice.sv
module evt_ctr_slice #(
    parameter int CTR_W   = 32,
    parameter int NUM_EVT = 64
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  run_i,
    input  logic                  clr_i,
    input  evt_pkg::lane_t        lane_i,
    input  logic [NUM_EVT-1:0]    evt_i,
    input  logic                  load_i,
    input  logic [CTR_W-1:0]      load_val_i,
    output logic [CTR_W-1:0]      cnt_o,
    output logic                  ovf_o
);
    localparam int EXT_W = 1 << evt_pkg::SEL_W;

    typedef struct packed {
        logic [CTR_W-1:0] cnt;
        logic             ovf;
    } slice_st_t;

    slice_st_t st_d, st_q;
    logic [EXT_W-1:0] evt_ext;
    logic hit;

    assign evt_ext = EXT_W'(evt_i);
    assign hit     = run_i && lane_i.en && evt_ext[lane_i.evt];

    always_comb begin
        st_d     = st_q;
        st_d.ovf = 1'b0;
        if (clr_i) begin
            st_d.cnt = '0;
        end else if (load_i) begin
            st_d.cnt = load_val_i;
        end else if (hit) begin
            st_d.cnt = st_q.cnt + CTR_W'(1);
            st_d.ovf = &st_q.cnt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;
    assign ovf_o = st_q.ovf;

    // R7: a wrap pulse always coincides with a counter reading zero
    assert_wrap_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> (cnt_o == '0));

    // R8: a preload lands unchanged on the next edge
    assert_preload_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !clr_i) |=> (cnt_o == $past(load_val_i)));

    // R3: with the bank stopped and no load or clear, the count holds
    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !load_i && !clr_i) |=> $stable(cnt_o));
endmodule

// File: rtl/evt_cyc_ctr.sv
module evt_cyc_ctr #(
    parameter int CYC_W = 56
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             clr_i,
    output logic [CYC_W-1:0] cyc_o
);
    typedef struct packed {
        logic [CYC_W-1:0] cyc;
    } cyc_st_t;

    cyc_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i)      st_d.cyc = '0;
        else if (run_i) st_d.cyc = st_q.cyc + CYC_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cyc_o = st_q.cyc;

    // R6: each running cycle adds exactly one, including the carry across the word split
    assert_cycle_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !clr_i) |=> (cyc_o == $past(cyc_o) + CYC_W'(1)));
endmodule

// File: rtl/evt_ctr_bank.sv
module evt_ctr_bank #(
    parameter int NUM_CTR = 16,
    parameter int CTR_W   = 32,
    parameter int NUM_EVT = 64,
    parameter int CYC_W   = 56
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        reg_wr,
    input  logic [evt_pkg::ADDR_W-1:0]  reg_addr,
    input  logic [evt_pkg::BUS_W-1:0]   reg_wdata,
    output logic [evt_pkg::BUS_W-1:0]   reg_rdata,
    input  logic [NUM_EVT-1:0]          evt_in,
    output logic [NUM_CTR-1:0]          ovf_pulse
);
    import evt_pkg::*;

    localparam int LANES_PER_WORD = BUS_W / 8;
    localparam int NUM_SEL_WORDS  = (NUM_CTR + LANES_PER_WORD - 1) / LANES_PER_WORD;
    localparam int CYC_HI_W       = CYC_W - BUS_W;

    typedef struct packed {
        logic                      run;
        logic [7:0]                tsel;
        lane_t [NUM_CTR-1:0]       lanes;
    } bank_st_t;

    bank_st_t st_d, st_q;

    logic wr_ctrl, wr_tsel, wr_pre, clr, tsel_ok;
    logic [7:0] tsel_idx;
    logic [NUM_CTR-1:0] load;
    logic [CTR_W-1:0] cnt_w [NUM_CTR];
    logic [CYC_W-1:0] cyc_w;

    assign wr_ctrl  = reg_wr && (reg_addr == OFS_CTRL);
    assign wr_tsel  = reg_wr && (reg_addr == OFS_TSEL);
    assign wr_pre   = reg_wr && (reg_addr == OFS_PRELOAD);
    assign clr      = wr_ctrl && reg_wdata[CTRL_CLEAR];
    assign tsel_idx = st_q.tsel - 8'(TSEL_BASE);
    assign tsel_ok  = (st_q.tsel >= 8'(TSEL_BASE)) && (st_q.tsel < 8'(TSEL_BASE + NUM_CTR));

    always_comb begin
        st_d = st_q;
        if (wr_ctrl) begin
            if (reg_wdata[CTRL_CLEAR])     st_d.run = 1'b0;
            else if (reg_wdata[CTRL_STOP]) st_d.run = 1'b0;
            else if (reg_wdata[CTRL_START]) st_d.run = 1'b1;
        end
        if (wr_tsel) st_d.tsel = reg_wdata[7:0];
        for (int w = 0; w < NUM_SEL_WORDS; w++) begin
            if (reg_wr && reg_addr == OFS_SEL0 + ADDR_W'(4 * w)) begin
                for (int k = 0; k < LANES_PER_WORD; k++) begin
                    if (w * LANES_PER_WORD + k < NUM_CTR) begin
                        st_d.lanes[w * LANES_PER_WORD + k].en  = reg_wdata[8 * k + 7];
                        st_d.lanes[w * LANES_PER_WORD + k].evt = reg_wdata[8 * k +: SEL_W];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar n = 0; n < NUM_CTR; n++) begin : g_ctr
        assign load[n] = wr_pre && tsel_ok && (tsel_idx == 8'(n));
        evt_ctr_slice #(.CTR_W(CTR_W), .NUM_EVT(NUM_EVT)) u_slice (
            .clk        (clk),
            .rst_n      (rst_n),
            .run_i      (st_q.run),
            .clr_i      (clr),
            .lane_i     (st_q.lanes[n]),
            .evt_i      (evt_in),
            .load_i     (load[n]),
            .load_val_i (CTR_W'(reg_wdata)),
            .cnt_o      (cnt_w[n]),
            .ovf_o      (ovf_pulse[n])
        );
    end

    evt_cyc_ctr #(.CYC_W(CYC_W)) u_cyc (
        .clk   (clk),
        .rst_n (rst_n),
        .run_i (st_q.run),
        .clr_i (clr),
        .cyc_o (cyc_w)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == OFS_STATE)       reg_rdata = BUS_W'(st_q.run);
        else if (reg_addr == OFS_TSEL)   reg_rdata = BUS_W'(st_q.tsel);
        else if (reg_addr == OFS_CYC_HI) reg_rdata = BUS_W'(cyc_w[CYC_W-1 -: CYC_HI_W]);
        else if (reg_addr == OFS_CYC_LO) reg_rdata = cyc_w[BUS_W-1:0];
        for (int w = 0; w < NUM_SEL_WORDS; w++) begin
            if (reg_addr == OFS_SEL0 + ADDR_W'(4 * w)) begin
                for (int k = 0; k < LANES_PER_WORD; k++) begin
                    if (w * LANES_PER_WORD + k < NUM_CTR) begin
                        reg_rdata[8 * k +: 8] = {st_q.lanes[w * LANES_PER_WORD + k].en, 1'b0,
                                                 st_q.lanes[w * LANES_PER_WORD + k].evt};
                    end
                end
            end
        end
        for (int n = 0; n < NUM_CTR; n++) begin
            if (reg_addr == OFS_CNT0 + ADDR_W'(4 * n)) reg_rdata = BUS_W'(cnt_w[n]);
        end
    end

    // R2: a clear leaves the bank stopped
    assert_clear_stops_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !st_q.run);

    // R2: a plain start command sets the run state
    assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && reg_wdata[CTRL_START] && !reg_wdata[CTRL_STOP] && !reg_wdata[CTRL_CLEAR])
        |=> st_q.run);

    // R9: without a control write the run state cannot move
    assert_run_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ctrl |=> $stable(st_q.run));

    // R8: at most one counter is targeted by a preload
    assert_one_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(load));
endmodule

// File: tb/evt_ctr_bank_bench.sv
`timescale 1ns/100ps
module evt_ctr_bank_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [63:0] evt_in = '0;
    logic [15:0] ovf_pulse;

    always #2.5 clk = ~clk;

    evt_ctr_bank u_evt_ctr_bank (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_in(evt_in),
        .ovf_pulse(ovf_pulse)
    );

    // behavioural reference
    bit [31:0] m_cnt [16];
    bit [7:0]  m_lane [16];
    bit [55:0] m_cyc;
    bit        m_run;
    bit [7:0]  m_tsel;
    bit [15:0] m_ovf;

    int n_chk = 0;
    int n_bad = 0;
    bit chk_on = 1'b0;
    bit done = 1'b0;
    string req_tag = "";

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_cnt[i]) begin m_cnt[i] = 0; m_lane[i] = 0; end
            m_cyc = 0; m_run = 0; m_tsel = 0; m_ovf = 0;
        end else begin
            bit clear_now;
            int t;
            clear_now = reg_wr && reg_addr == 12'hC00 && reg_wdata[2];
            t = int'(m_tsel) - 19;
            m_ovf = 0;
            for (int i = 0; i < 16; i++) begin
                if (clear_now) m_cnt[i] = 0;
                else if (reg_wr && reg_addr == 12'hC0C && t == i) m_cnt[i] = reg_wdata;
                else if (m_run && m_lane[i][7] && evt_in[m_lane[i][5:0]]) begin
                    if (m_cnt[i] == 32'hFFFF_FFFF) m_ovf[i] = 1'b1;
                    m_cnt[i] = m_cnt[i] + 1;
                end
            end
            if (clear_now) m_cyc = 0;
            else if (m_run) m_cyc = m_cyc + 1;
            if (reg_wr) begin
                if (reg_addr == 12'hC00) begin
                    if (reg_wdata[2] || reg_wdata[1]) m_run = 0;
                    else if (reg_wdata[0]) m_run = 1;
                end
                if (reg_addr == 12'hC08) m_tsel = reg_wdata[7:0];
                for (int w = 0; w < 4; w++)
                    if (reg_addr == 12'hC68 + 12'(4 * w))
                        for (int k = 0; k < 4; k++)
                            m_lane[4 * w + k] = reg_wdata[8 * k +: 8] & 8'hBF;
            end
        end
    end

    function automatic bit [31:0] m_read(input bit [11:0] a);
        bit [31:0] r = 0;
        if (a == 12'hC04) r = {31'b0, m_run};
        else if (a == 12'hC08) r = {24'b0, m_tsel};
        else if (a == 12'hC10) r = {8'b0, m_cyc[55:32]};
        else if (a == 12'hC14) r = m_cyc[31:0];
        else if (a >= 12'hC68 && a < 12'hC78 && a[1:0] == 0)
            for (int k = 0; k < 4; k++) r[8 * k +: 8] = m_lane[((a - 12'hC68) >> 2) * 4 + k];
        else if (a >= 12'hC78 && a < 12'hCB8 && a[1:0] == 0) r = m_cnt[(a - 12'hC78) >> 2];
        return r;
    endfunction

    function automatic string tag_of(input bit [11:0] a);
        if (req_tag != "") return req_tag;
        if (a == 12'hC00 || a == 12'hC04) return "R2";
        if (a == 12'hC08 || a == 12'hC0C) return "R8";
        if (a == 12'hC10 || a == 12'hC14) return "R6";
        if (a >= 12'hC68 && a < 12'hC78 && a[1:0] == 0) return "R4";
        if (a >= 12'hC78 && a < 12'hCB8 && a[1:0] == 0) return "R5";
        return "R9";
    endfunction

    always @(negedge clk) begin
        if (chk_on && !done) begin
            bit [31:0] exp_r;
            exp_r = m_read(reg_addr);
            n_chk++;
            if (reg_rdata !== exp_r) begin
                n_bad++;
                $display("FAIL %s addr=%h got=%h exp=%h", tag_of(reg_addr), reg_addr, reg_rdata, exp_r);
            end
            n_chk++;
            if (ovf_pulse !== m_ovf) begin   // R7 wrap pulse
                n_bad++;
                $display("FAIL R7 ovf_pulse got=%h exp=%h", ovf_pulse, m_ovf);
            end
        end
    end

    task automatic idle(input bit [11:0] a);
        @(negedge clk); #1; reg_wr = 0; reg_addr = a;
    endtask

    task automatic wr(input bit [11:0] a, input bit [31:0] d);
        @(negedge clk); #1; reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); #1; reg_wr = 0;
    endtask

    task automatic sweep();
        for (bit [12:0] a = 13'hC00; a <= 13'hCD0; a += 4) idle(a[11:0]);
    endtask

    bit [63:0] lfsr = 64'h9E37_79B9_7F4A_7C15;
    task automatic run_rand(input int cycles, input bit [63:0] mask);
        for (int c = 0; c < cycles; c++) begin
            lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
            @(negedge clk); #1;
            evt_in = lfsr & mask;
            case (c % 4)
                0: reg_addr = 12'hC78 + 12'(4 * ((c / 4) % 16));
                1: reg_addr = 12'hC14;
                2: reg_addr = 12'hC10;
                default: reg_addr = 12'hC04;
            endcase
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(posedge clk);
        chk_on = 1;
        req_tag = "R1";               // R1 reset state across the whole map
        sweep();
        req_tag = "";
        // R4 lanes: counter n watches event 3n+1, bit 6 written but masked
        for (int w = 0; w < 4; w++) begin
            bit [31:0] d;
            for (int k = 0; k < 4; k++)
                d[8 * k +: 8] = 8'hC0 | 8'((3 * (4 * w + k) + 1) % 64);
            wr(12'hC68 + 12'(4 * w), d);
        end
        sweep();
        wr(12'hC00, 32'h1);           // R2 start
        req_tag = "R3";
        run_rand(300, '1);
        run_rand(100, 64'h0000_FFFF_0000_FFFF);
        req_tag = "";
        wr(12'hC00, 32'h2);           // R2 stop
        req_tag = "R3";
        run_rand(60, '1);             // no counting while stopped
        req_tag = "";
        // R8 preload through selector, then priority over increment
        wr(12'hC08, 32'd24);
        wr(12'hC0C, 32'hFFFF_FFF0);
        idle(12'hC08);
        idle(12'hC8C);
        evt_in = '1;
        wr(12'hC00, 32'h1);
        req_tag = "R8";
        repeat (3) idle(12'hC8C);
        wr(12'hC0C, 32'hFFFF_FFFA);   // load wins over increment
        req_tag = "R7";
        repeat (12) idle(12'hC8C);    // wrap of counter 5
        req_tag = "R8";
        wr(12'hC08, 32'd34);          // last counter
        wr(12'hC0C, 32'h1234_5678);
        idle(12'hCB4);
        wr(12'hC08, 32'd18);          // below range: ignored
        wr(12'hC0C, 32'h0BAD_0001);
        wr(12'hC08, 32'd35);          // above range: ignored
        wr(12'hC0C, 32'h0BAD_0002);
        wr(12'hC08, 32'h113);         // stores 0x13 -> counter 0
        wr(12'hC0C, 32'h0000_0055);
        wr(12'hC08, 32'd0);
        wr(12'hC0C, 32'h0BAD_0003);
        req_tag = "";
        sweep();
        // R9 unmapped, misaligned and read-only writes
        wr(12'hC18, 32'hFFFF_FFFF);
        wr(12'hC50, 32'hFFFF_FFFF);
        wr(12'hC6A, 32'hFFFF_FFFF);
        wr(12'hCFC, 32'hFFFF_FFFF);
        wr(12'hC78, 32'hFFFF_FFFF);   // R5 read-only counter
        wr(12'hC14, 32'hFFFF_FFFF);   // R6 read-only cycle
        wr(12'hC04, 32'h0);
        sweep();
        // R4 disabling lanes during run
        wr(12'hC6C, 32'h0);
        req_tag = "R4";
        run_rand(40, '1);
        req_tag = "";
        // R2 priority: clear with start, then stop with start
        wr(12'hC00, 32'h5);
        idle(12'hC04);
        idle(12'hC14);
        wr(12'hC00, 32'h1);
        run_rand(10, '1);
        wr(12'hC00, 32'h3);
        run_rand(10, '1);
        sweep();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog expired got=running exp=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule